// File: doc/BRIEF.md
# Module Configuration Memory Target

This block sits on a memory module and answers a host over a two-wire serial bus with the same signalling as I2C or SMBus. It keeps a byte array that describes the module. The host reads the array at boot to learn how to set up the memory. The block watches the SCL and SDA lines through synchronisers running on its own system clock. It finds START and STOP conditions, matches its 7-bit bus address and acknowledges the host. It returns data by pulling SDA low or releasing it, and never drives the line high.

The bus address is `1010` followed by the three strap pins, so eight modules can share one bus at 0x50 to 0x57. A write-direction transaction always begins with one byte that loads the internal pointer. Any further bytes in that transaction are stored at the pointer, which then advances. A read-direction transaction returns bytes starting at the pointer. The pointer steps by one for each byte fetched and wraps from the last location back to zero. For a random read, the host sends the pointer byte, a repeated START, then the read address.

A write-direction access to a second, fixed lock address sets a write-protect latch. After that, every data write is acknowledged and discarded. Only a reset clears the latch. Reset does not clear the stored bytes.

Top module: `spd_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {4'b1010, strap_i}. For any other address, apart from the lock address in R9, it returns no acknowledge and leaves SDA released until the next START.
- R2: SDA is only ever pulled low (sda_oe_o=1) or released (sda_oe_o=0). It is released after reset, and sda_oe_o changes only while SCL is low.
- R3: In a write-direction transaction, the first byte after the address is acknowledged and loaded into the pointer.
- R4: A repeated START followed by a read-direction address returns the byte at the pointer just loaded, most significant bit first.
- R5: In a read, each acknowledged byte is followed by the byte at the next location. The location after the last one (255 by default) is 0.
- R6: The host ends a read by answering a byte with NACK. The block then releases SDA, and the next read without a pointer write starts just after the last byte returned.
- R7: Reset sets the pointer to 0 and leaves the stored bytes unchanged. A read with no pointer write returns bytes from the current pointer.
- R8: In a write-direction transaction, each data byte after the pointer byte is acknowledged, stored at the pointer, and the pointer then advances by one with wrap.
- R9: A write-direction address to LOCK_ADDR (default 7'h3A) is acknowledged and sets a write-protect latch that only reset clears. A read-direction address to LOCK_ADDR is not acknowledged. While the latch is set, data bytes are still acknowledged but leave the array unchanged.
- R10: A STOP at any point returns the block to idle with SDA released. A START at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Board strap pins giving the low three address bits |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench goes after pointer wrap at the top of the array: a design that saturates or does not wrap would return the wrong third byte of a read that starts at 0xFE. It also checks where a current-address read resumes after a NACK-terminated read, which an off-by-one in the increment shows as a shifted byte. Writes after the lock are acknowledged yet must leave the old data readable; a design that ignores the latch returns the new byte. Changing the strap pins at runtime and sending a STOP in the middle of a read show whether the address compare uses the live straps and whether a design left mid-transfer keeps SDA held.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WORD,
        ST_WACK,
        ST_DATA,
        ST_TX,
        ST_MACK
    } spd_state_e;

    localparam logic [3:0] DEV_TYPE_ID = 4'b1010;

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= synced;
        end
    end

    assign scl_s    = synced[0];
    assign sda_s    = synced[1];
    assign scl_rise = synced[0] & ~prev_q[0];
    assign scl_fall = ~synced[0] & prev_q[0];
    assign start_ev = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
    assign stop_ev  = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];

endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spd_target.sv
module spd_target
    import spd_pkg::*;
#(
    parameter int         AW        = 8,
    parameter int         SYNC_LEN  = 2,
    parameter logic [6:0] LOCK_ADDR = 7'h3A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o
);
    localparam int DW   = 8;
    localparam int CW   = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        spd_state_e    st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sr;
        logic [AW-1:0] ptr;
        logic          oe;
        logic          rw;
        logic          lk_tgt;
        logic          lock;
        logic          mack;
    } regs_t;

    regs_t q, d;

    logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic          mem_we;
    logic [DW-1:0] rdata;
    logic [6:0]    my_addr;

    spd_line_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    spd_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (q.ptr),
        .wdata (q.sr),
        .raddr (q.ptr),
        .rdata (rdata)
    );

    assign my_addr = {DEV_TYPE_ID, strap_i};

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (start_ev) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WORD, ST_DATA: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.sr  = {q.sr[DW-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sr[7:1] == my_addr) begin
                                d.oe     = 1'b1;
                                d.rw     = q.sr[0];
                                d.lk_tgt = 1'b0;
                                d.st     = ST_AACK;
                            end else if (q.sr[7:1] == LOCK_ADDR && !q.sr[0]) begin
                                d.oe     = 1'b1;
                                d.lk_tgt = 1'b1;
                                d.lock   = 1'b1;
                                d.st     = ST_AACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_WORD) begin
                            d.ptr = q.sr[AW-1:0];
                            d.oe  = 1'b1;
                            d.st  = ST_WACK;
                        end else begin
                            mem_we = !q.lock;
                            d.ptr  = q.ptr + 1'b1;
                            d.oe   = 1'b1;
                            d.st   = ST_WACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.lk_tgt) begin
                            d.st = ST_IDLE;
                        end else if (q.rw) begin
                            d.sr  = rdata;
                            d.oe  = ~rdata[DW-1];
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_TX;
                        end else begin
                            d.st = ST_WORD;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_DATA;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.oe = 1'b0;
                            d.st = ST_MACK;
                        end else begin
                            d.oe  = ~q.sr[DW-2];
                            d.sr  = {q.sr[DW-2:0], 1'b0};
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = sda_s;
                    end else if (scl_fall) begin
                        if (!q.mack) begin
                            d.sr  = rdata;
                            d.oe  = ~rdata[DW-1];
                            d.ptr = q.ptr + 1'b1;
                            d.cnt = '0;
                            d.st  = ST_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sr: '0, ptr: '0, oe: 1'b0,
                   rw: 1'b0, lk_tgt: 1'b0, lock: 1'b0, mack: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

endmodule

// File: rtl/spd_target_chk.sv
module spd_target_chk
    import spd_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input spd_state_e    st,
    input logic          stop_ev,
    input logic          lock,
    input logic [AW-1:0] ptr
);
    // R2: drive changes only while the synchronised clock is low
    a_r2_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R1 / R2: no drive while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R10: a STOP returns the controller to idle
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE));

    // R9: the protect latch never clears outside reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock) |-> lock);

    // R5: each fetched byte advances the pointer by one
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && $past(st) != ST_TX) |-> (ptr == $past(ptr) + 1'b1));

endmodule

bind spd_target spd_target_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe_o),
    .st      (q.st),
    .stop_ev (stop_ev),
    .lock    (q.lock),
    .ptr     (q.ptr)
);

// File: tb/spd_target_tb.sv
module spd_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 4;
    localparam int HALF       = 12;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       sda_oe;
    wire        sda_line = sda_h & ~sda_oe;

    int checks = 0;
    int failures = 0;
    int hi_changes = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spd_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (strap),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wclk(QTR); sda_h = 1'b1; wclk(HALF); scl_h = 1'b1;
        wclk(HALF); sda_h = 1'b0; wclk(HALF); scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(QTR); sda_h = 1'b0; wclk(HALF); scl_h = 1'b1;
        wclk(HALF); sda_h = 1'b1; wclk(HALF);
    endtask

    task automatic send(logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wclk(QTR); sda_h = b[i]; wclk(HALF - QTR);
            scl_h = 1'b1; wclk(HALF); scl_h = 1'b0;
        end
        wclk(QTR); sda_h = 1'b1; wclk(HALF - QTR);
        scl_h = 1'b1; wclk(HALF / 2); ack = ~sda_line;
        wclk(HALF / 2); scl_h = 1'b0;
    endtask

    task automatic send_chk(logic [7:0] b, bit exp_ack, string tag);
        bit a;
        send(b, a);
        chk(tag, {7'd0, a}, {7'd0, exp_ack});
    endtask

    task automatic recv(bit last);
        logic [7:0] b;
        wclk(QTR); sda_h = 1'b1; wclk(HALF - QTR);
        for (int i = 7; i >= 0; i--) begin
            scl_h = 1'b1; wclk(HALF / 2); b[i] = sda_line;
            wclk(HALF / 2); scl_h = 1'b0;
            if (i > 0) wclk(HALF);
        end
        wclk(QTR); sda_h = last; wclk(HALF - QTR);
        scl_h = 1'b1; wclk(HALF); scl_h = 1'b0;
        act_q.push_back(b);
    endtask

    task automatic expect_byte(logic [7:0] b, string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                logic [7:0] a;
                logic [7:0] e;
                string t;
                a = act_q.pop_front();
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, a, e);
                end else begin
                    chk("SCOREBOARD", a, 8'hxx);
                end
            end
        end
    end

    // R2: watch for drive changes while SCL is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_h) hi_changes++;
        oe_prev <= sda_oe;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL WATCHDOG actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wclk(5); rst_n = 1'b1; wclk(5);
        chk("R2 reset release", {7'd0, sda_oe}, 8'd0);

        // R1: wrong address is ignored
        bus_start(); send_chk(8'hA2, 1'b0, "R1 wrong addr nack"); bus_stop();
        chk("R1 released after nack", {7'd0, sda_oe}, 8'd0);

        // prepare locations 0 and 1, then reset (R7)
        bus_start(); send_chk(8'hAA, 1'b1, "R1 own addr ack");
        send_chk(8'h00, 1'b1, "R3 pointer ack");
        send_chk(8'h3C, 1'b1, "R8 data ack");
        send_chk(8'h4D, 1'b1, "R8 data ack");
        bus_stop();
        rst_n = 1'b0; wclk(3); rst_n = 1'b1; wclk(5);
        bus_start(); send_chk(8'hAB, 1'b1, "R7 read addr ack");
        expect_byte(8'h3C, "R7 ptr zero after reset");
        expect_byte(8'h4D, "R7 sequential");
        recv(1'b0); recv(1'b1); bus_stop();

        // R8 write burst at 0x10
        bus_start(); send_chk(8'hAA, 1'b1, "R8 addr ack");
        send_chk(8'h10, 1'b1, "R3 pointer ack");
        send_chk(8'hA1, 1'b1, "R8 ack0");
        send_chk(8'hB2, 1'b1, "R8 ack1");
        send_chk(8'hC3, 1'b1, "R8 ack2");
        send_chk(8'hD4, 1'b1, "R8 ack3");
        send_chk(8'hE5, 1'b1, "R8 ack4");
        bus_stop();

        // R4 random read with R5 sequence
        bus_start(); send_chk(8'hAA, 1'b1, "R4 addr ack");
        send_chk(8'h10, 1'b1, "R3 pointer ack");
        bus_start(); send_chk(8'hAB, 1'b1, "R4 read ack");
        expect_byte(8'hA1, "R4 first byte");
        expect_byte(8'hB2, "R5 seq1");
        expect_byte(8'hC3, "R5 seq2");
        expect_byte(8'hD4, "R5 seq3");
        recv(1'b0); recv(1'b0); recv(1'b0); recv(1'b1); bus_stop();
        chk("R6 released after nack", {7'd0, sda_oe}, 8'd0);

        // R6 continuation read
        bus_start(); send_chk(8'hAB, 1'b1, "R6 read ack");
        expect_byte(8'hE5, "R6 resume after last byte");
        recv(1'b1); bus_stop();

        // R5 wrap
        bus_start(); send_chk(8'hAA, 1'b1, "R5 addr ack");
        send_chk(8'hFE, 1'b1, "R3 pointer ack");
        send_chk(8'hEE, 1'b1, "R8 wrap ack0");
        send_chk(8'hFF, 1'b1, "R8 wrap ack1");
        send_chk(8'h11, 1'b1, "R8 wrap ack2");
        bus_stop();
        bus_start(); send_chk(8'hAA, 1'b1, "R5 addr ack");
        send_chk(8'hFE, 1'b1, "R3 pointer ack");
        bus_start(); send_chk(8'hAB, 1'b1, "R5 read ack");
        expect_byte(8'hEE, "R5 at 0xFE");
        expect_byte(8'hFF, "R5 at 0xFF");
        expect_byte(8'h11, "R5 wrapped to 0x00");
        recv(1'b0); recv(1'b0); recv(1'b1); bus_stop();

        // R9 lock
        bus_start(); send_chk(8'h75, 1'b0, "R9 lock read nack"); bus_stop();
        bus_start(); send_chk(8'h74, 1'b1, "R9 lock write ack"); bus_stop();
        bus_start(); send_chk(8'hAA, 1'b1, "R9 addr ack");
        send_chk(8'h10, 1'b1, "R9 pointer ack");
        send_chk(8'h99, 1'b1, "R9 locked data ack");
        bus_stop();
        bus_start(); send_chk(8'hAA, 1'b1, "R9 addr ack");
        send_chk(8'h10, 1'b1, "R9 pointer ack");
        bus_start(); send_chk(8'hAB, 1'b1, "R9 read ack");
        expect_byte(8'hA1, "R9 locked byte unchanged");
        recv(1'b1); bus_stop();

        // R10 STOP in the middle of a read
        bus_start(); send_chk(8'hAA, 1'b1, "R10 addr ack");
        send_chk(8'h11, 1'b1, "R10 pointer ack");
        bus_start(); send_chk(8'hAB, 1'b1, "R10 read ack");
        expect_byte(8'hB2, "R10 byte before stop");
        recv(1'b0); bus_stop();
        chk("R10 released after stop", {7'd0, sda_oe}, 8'd0);
        bus_start(); send_chk(8'hAA, 1'b1, "R10 addr ack after stop");
        send_chk(8'h12, 1'b1, "R10 pointer ack");
        bus_start(); send_chk(8'hAB, 1'b1, "R10 read ack");
        expect_byte(8'hC3, "R10 fresh transaction");
        recv(1'b1); bus_stop();

        // R1 strap change
        strap = 3'b010; wclk(4);
        bus_start(); send_chk(8'hAA, 1'b0, "R1 old strap nack"); bus_stop();
        bus_start(); send_chk(8'hA4, 1'b1, "R1 new strap ack"); bus_stop();

        chk("R2 no drive change with SCL high", hi_changes[7:0], 8'd0);

        wait (act_q.size() == 0);
        wclk(2);
        chk("SCOREBOARD drained", exp_q.size() == 0 ? 8'd0 : 8'd1, 8'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule